// File: doc/BRIEF.md
# I2C-over-AUX Transfer Sequencer

This block turns one I2C message into the series of AUX-channel I2C packets needed to carry it. A message is a 7-bit target address, a direction and a byte length. The block first sends an address-only packet with the middle-of-transaction flag (MOT) set. It then sends data packets of at most `MAX_CHUNK` bytes, each pointing at a byte offset in the caller's buffer. Last, it always sends an address-only packet with MOT cleared. Each packet goes to a downstream transfer engine over a valid/response handshake.

Every response carries two reply fields, one for the native AUX layer and one for the I2C layer. The sequencer decides from them whether the packet succeeded, must be retried after a wait, or has failed. The retry budget depends on the packet size and grows with each I2C-level defer. If a write is deferred or only partly accepted, the next request becomes a write-status-update so the remaining bytes are drained. After a short reply, later packets shrink to the smallest count seen. A one-cycle `done_o` pulse ends the message, with a status code.

Top module: `aux_i2c_seq`

## Requirements
- R1: After a message is accepted, the first request has size 0 and MOT set. The command is `{1'b0, MOT, code}` with MOT at bit 2 and code read = 1, write = 0, write-status-update = 2.
- R2: The data bytes are requested in packets of at most `MAX_CHUNK` bytes. `req_ptr_o` holds the byte offset of the first byte of each packet. With all-full replies, a message of N bytes needs 2 + ceil(N/`MAX_CHUNK`) requests.
- R3: Every message ends with a size-0 request that has MOT clear and the plain read or write code. This happens even after an error. `done_o` pulses in the cycle after that request's response.
- R4: Reply bits [1:0] are the native field and bits [3:2] are the I2C field. In both, ACK = 0, NACK = 1, DEFER = 2 and 3 is invalid. Only ACK in both fields counts as success. Each of the following ends the message with status 1 (remote I/O): a native NACK, an invalid native value, an I2C NACK (under native ACK), or an invalid I2C value. A fully successful message has status 0.
- R5: After a native DEFER or an I2C DEFER, the same packet is reissued after a wait of `DEFER_WAIT` cycles. After `rsp_busy_i`, the packet is reissued after a one-cycle gap, and that attempt also counts.
- R6: The base attempt limit for a packet of S bytes is max(7, ceil(T_i2c / (T_aux + 500))). Here T_i2c = ceil((11 + 9·S)·1000 / `I2C_KHZ`) and T_aux = 108 + 8·S. When the limit is used up without success, the message ends with status 1.
- R7: Each I2C DEFER on a packet raises that packet's limit by one, by at most 7 in total.
- R8: An I2C DEFER on a write, or a successful write reply whose count is below the requested size, makes the next request write-status-update with MOT kept. Reads never change code. The plain code is restored at the start of every new packet group (next chunk or closing packet).
- R9: After a short reply, the rest of the packet is requested from the advanced offset. All later packets are limited to the smallest short count seen.
- R10: A successful data reply with count 0 ends the message with status 2 (protocol error).
- R11: `nack_events_o` counts I2C NACK replies and `defer_events_o` counts I2C DEFER replies.
- R12: Out of reset, `msg_ready_o` is 1, while `req_valid_o`, `done_o` and both event counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Start a message (taken when `msg_ready_o`) |
| msg_read_i | input | 1 | 1 = read message, 0 = write message |
| msg_addr_i | input | 7 | I2C target address |
| msg_len_i | input | LEN_W | Message length in bytes |
| msg_ready_o | output | 1 | Sequencer idle, can take a message |
| req_valid_o | output | 1 | Request to the transfer engine pending |
| req_cmd_o | output | 4 | Request command: bit 2 MOT, bits 1:0 code |
| req_addr_o | output | 7 | I2C target address of the request |
| req_size_o | output | SZ_W | Bytes in this request (0 = address only) |
| req_ptr_o | output | LEN_W | Buffer offset of the first byte |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_busy_i | input | 1 | Engine was busy; retry the request |
| rsp_reply_i | input | 4 | Reply: bits 1:0 native, bits 3:2 I2C |
| rsp_count_i | input | SZ_W | Bytes the reply accounted for |
| done_o | output | 1 | One-cycle pulse at message end |
| status_o | output | 2 | 0 ok, 1 remote I/O error, 2 protocol error |
| nack_events_o | output | CNT_W | I2C NACK count |
| defer_events_o | output | CNT_W | I2C DEFER count |

## Verification
The bench builds the block with `MAX_CHUNK` = 16, `I2C_KHZ` = 10 and `DEFER_WAIT` = 8. At these values a 16-byte packet gets a base limit of 22 attempts, while an address-only packet gets the floor of 7. Both the size-dependent limit and the floor can therefore be hit exactly, including the success on the last allowed attempt. The short wait makes the defer gap measurable to the cycle. The 40-byte and 33-byte messages exercise multi-packet splitting, partial-reply shrinking and the final short packet.

// File: rtl/aux_i2c_seq_pkg.sv
package aux_i2c_seq_pkg;

  localparam int MOT_BIT = 2;

  typedef enum logic [1:0] {CODE_WR = 2'd0, CODE_RD = 2'd1, CODE_WSU = 2'd2} i2c_code_e;
  typedef enum logic [1:0] {RPL_ACK = 2'd0, RPL_NACK = 2'd1, RPL_DEFER = 2'd2} reply_e;
  typedef enum logic [1:0] {STS_OK = 2'd0, STS_RIO = 2'd1, STS_PROTO = 2'd2} seq_status_e;
  typedef enum logic [1:0] {PH_START, PH_DATA, PH_CLOSE} phase_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  // request: precharge+sync+stop+cmd+addr+len ; reply: precharge+sync+stop+cmd+pad
  localparam int AUX_REQ_BITS = 66;
  localparam int AUX_RPL_BITS = 42;
  localparam int I2C_FIXED_BITS = 11;  // start + addr/rw/ack + stop

  function automatic int retry_base(input int size, input int khz, input int floor_n,
                                    input int gap_us);
    int i2c_us, aux_us, q;
    i2c_us = ((I2C_FIXED_BITS + 9 * size) * 1000 + khz - 1) / khz;
    aux_us = AUX_REQ_BITS + AUX_RPL_BITS + 8 * size + gap_us;
    q = (i2c_us + aux_us - 1) / aux_us;
    return (q < floor_n) ? floor_n : q;
  endfunction

endpackage

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_i2c_seq_pkg::*;
#(
  parameter int MAX_CHUNK  = 16,
  parameter int SZ_W       = 5,
  parameter int I2C_KHZ    = 10,
  parameter int MIN_RETRY  = 7,
  parameter int MAX_EXTRA  = 7,
  parameter int GAP_US     = 500,
  parameter int DEFER_WAIT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            fail_i,
  input  logic            i2c_defer_i,
  input  logic            wait_i,
  input  logic [SZ_W-1:0] size_i,
  output logic            give_up_o,
  output logic            wait_done_o
);
  localparam int BASE_MAX = retry_base(MAX_CHUNK, I2C_KHZ, MIN_RETRY, GAP_US);
  localparam int ATT_W    = $clog2(BASE_MAX + MAX_EXTRA + 1) + 2;
  localparam int EXT_W    = $clog2(MAX_EXTRA + 1) + 1;
  localparam int WAIT_W   = $clog2(DEFER_WAIT + 1) + 1;
  localparam int N_TBL    = 2 ** SZ_W;

  logic [ATT_W-1:0] base_tbl [N_TBL];

  for (genvar g = 0; g < N_TBL; g++) begin : g_base
    localparam int SZ = (g > MAX_CHUNK) ? MAX_CHUNK : g;
    assign base_tbl[g] = ATT_W'(retry_base(SZ, I2C_KHZ, MIN_RETRY, GAP_US));
  end

  logic [ATT_W-1:0]  att_q, att_nx, limit_nx;
  logic [EXT_W-1:0]  ext_q, ext_nx;
  logic [WAIT_W-1:0] tmr_q;

  assign ext_nx    = (i2c_defer_i && ext_q < EXT_W'(MAX_EXTRA)) ? ext_q + 1'b1 : ext_q;
  assign att_nx    = att_q + 1'b1;
  assign limit_nx  = base_tbl[size_i] + ATT_W'(ext_nx);
  assign give_up_o = att_nx >= limit_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q <= '0;
      ext_q <= '0;
    end else if (clr_i) begin
      att_q <= '0;
      ext_q <= '0;
    end else if (fail_i) begin
      att_q <= att_nx;
      ext_q <= ext_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= '0;
    else if (wait_i)        tmr_q <= WAIT_W'(DEFER_WAIT);
    else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign wait_done_o = (tmr_q == '0);

  // R6
  att_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q < base_tbl[size_i] + ATT_W'(ext_q));
  // R7
  extra_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= EXT_W'(MAX_EXTRA));
  // R7
  extra_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ext_q <= $past(ext_q) + 1'b1);

endmodule

// File: rtl/aux_chunk_ctrl.sv
module aux_chunk_ctrl #(
  parameter int LEN_W     = 8,
  parameter int MAX_CHUNK = 16,
  parameter int SZ_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  input  logic [SZ_W-1:0]  cnt_i,
  output logic [SZ_W-1:0]  seg_left_o,
  output logic [LEN_W-1:0] ptr_o,
  output logic             seg_end_o,
  output logic             msg_end_o,
  output logic             short_o
);
  logic [LEN_W-1:0] left_q, ptr_q, left_nx;
  logic [SZ_W-1:0]  seg_q, lim_q, minr_q, cnt_eff, minr_upd;

  function automatic logic [SZ_W-1:0] clip(input logic [SZ_W-1:0] lim,
                                           input logic [LEN_W-1:0] left);
    return (left < LEN_W'(lim)) ? left[SZ_W-1:0] : lim;
  endfunction

  assign cnt_eff   = (cnt_i > seg_q) ? seg_q : cnt_i;
  assign left_nx   = left_q - LEN_W'(cnt_eff);
  assign short_o   = cnt_i < seg_q;
  assign seg_end_o = !short_o;
  assign msg_end_o = LEN_W'(cnt_eff) >= left_q;
  assign minr_upd  = (short_o && cnt_i < minr_q) ? cnt_i : minr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ptr_q  <= '0;
      seg_q  <= '0;
      lim_q  <= SZ_W'(MAX_CHUNK);
      minr_q <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      ptr_q  <= '0;
      lim_q  <= SZ_W'(MAX_CHUNK);
      seg_q  <= clip(SZ_W'(MAX_CHUNK), len_i);
      minr_q <= clip(SZ_W'(MAX_CHUNK), len_i);
    end else if (adv_i) begin
      ptr_q  <= ptr_q + LEN_W'(cnt_eff);
      left_q <= left_nx;
      if (seg_end_o) begin
        lim_q  <= minr_upd;
        seg_q  <= clip(minr_upd, left_nx);
        minr_q <= clip(minr_upd, left_nx);
      end else begin
        seg_q  <= seg_q - cnt_eff;
        minr_q <= minr_upd;
      end
    end
  end

  assign seg_left_o = seg_q;
  assign ptr_o      = ptr_q;

  // R2
  seg_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q <= lim_q && LEN_W'(seg_q) <= left_q);
  // R9
  lim_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> lim_q <= $past(lim_q));

endmodule

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq
  import aux_i2c_seq_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int MAX_CHUNK  = 16,
  parameter int I2C_KHZ    = 10,
  parameter int DEFER_WAIT = 8,
  parameter int CNT_W      = 16,
  localparam int SZ_W      = $clog2(MAX_CHUNK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic             msg_read_i,
  input  logic [6:0]       msg_addr_i,
  input  logic [LEN_W-1:0] msg_len_i,
  output logic             msg_ready_o,
  output logic             req_valid_o,
  output logic [3:0]       req_cmd_o,
  output logic [6:0]       req_addr_o,
  output logic [SZ_W-1:0]  req_size_o,
  output logic [LEN_W-1:0] req_ptr_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_busy_i,
  input  logic [3:0]       rsp_reply_i,
  input  logic [SZ_W-1:0]  rsp_count_i,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [CNT_W-1:0] nack_events_o,
  output logic [CNT_W-1:0] defer_events_o
);
  seq_state_e  state_q;
  phase_e      phase_q;
  i2c_code_e   code_q;
  seq_status_e sts_q;
  logic        mot_q, rd_q, zlen_q, done_q;
  logic [6:0]  addr_q;
  logic [CNT_W-1:0] nack_q, defer_q;

  logic [1:0] nat, i2c;
  logic rsp_now, accept, nat_defer, i2c_defer, i2c_nack, retry, ok, zero, good, fatal;
  logic give_up, wait_done;
  logic [SZ_W-1:0]  seg_left;
  logic [LEN_W-1:0] ptr;
  logic seg_end, msg_end, short_rpl;
  i2c_code_e plain;

  assign accept    = (state_q == S_IDLE) && msg_valid_i;
  assign rsp_now   = (state_q == S_ISSUE) && rsp_valid_i;
  assign nat       = rsp_reply_i[1:0];
  assign i2c       = rsp_reply_i[3:2];
  assign nat_defer = !rsp_busy_i && nat == RPL_DEFER;
  assign i2c_defer = !rsp_busy_i && nat == RPL_ACK && i2c == RPL_DEFER;
  assign i2c_nack  = !rsp_busy_i && nat == RPL_ACK && i2c == RPL_NACK;
  assign retry     = rsp_busy_i || nat_defer || i2c_defer;
  assign ok        = !rsp_busy_i && nat == RPL_ACK && i2c == RPL_ACK;
  assign zero      = ok && phase_q == PH_DATA && rsp_count_i == '0;
  assign good      = ok && !zero;
  assign fatal     = rsp_now && ((!retry && !ok) || (retry && give_up) || zero);
  assign plain     = rd_q ? CODE_RD : CODE_WR;

  aux_retry_ctrl #(
    .MAX_CHUNK(MAX_CHUNK), .SZ_W(SZ_W), .I2C_KHZ(I2C_KHZ), .MIN_RETRY(7),
    .MAX_EXTRA(7), .GAP_US(500), .DEFER_WAIT(DEFER_WAIT)
  ) u_retry (
    .clk_i,
    .rst_ni,
    .clr_i      (accept || (rsp_now && (good || fatal))),
    .fail_i     (rsp_now && retry && !give_up),
    .i2c_defer_i(i2c_defer),
    .wait_i     (rsp_now && (nat_defer || i2c_defer) && !give_up),
    .size_i     (req_size_o),
    .give_up_o  (give_up),
    .wait_done_o(wait_done)
  );

  aux_chunk_ctrl #(
    .LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .SZ_W(SZ_W)
  ) u_chunk (
    .clk_i,
    .rst_ni,
    .load_i    (accept),
    .len_i     (msg_len_i),
    .adv_i     (rsp_now && good && phase_q == PH_DATA),
    .cnt_i     (rsp_count_i),
    .seg_left_o(seg_left),
    .ptr_o     (ptr),
    .seg_end_o (seg_end),
    .msg_end_o (msg_end),
    .short_o   (short_rpl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_START;
      code_q  <= CODE_WR;
      sts_q   <= STS_OK;
      mot_q   <= 1'b0;
      rd_q    <= 1'b0;
      zlen_q  <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (msg_valid_i) begin
          addr_q  <= msg_addr_i;
          rd_q    <= msg_read_i;
          code_q  <= msg_read_i ? CODE_RD : CODE_WR;
          mot_q   <= 1'b1;
          phase_q <= PH_START;
          sts_q   <= STS_OK;
          zlen_q  <= (msg_len_i == '0);
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (rsp_valid_i) begin
          if (fatal || (good && phase_q == PH_CLOSE)) begin
            if (phase_q == PH_CLOSE) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              sts_q   <= zero ? STS_PROTO : STS_RIO;
              phase_q <= PH_CLOSE;
              code_q  <= plain;
              mot_q   <= 1'b0;
              state_q <= S_WAIT;
            end
          end else if (good) begin
            state_q <= S_WAIT;
            if (phase_q == PH_START) begin
              code_q <= plain;
              if (zlen_q) begin
                phase_q <= PH_CLOSE;
                mot_q   <= 1'b0;
              end else begin
                phase_q <= PH_DATA;
              end
            end else if (msg_end) begin
              phase_q <= PH_CLOSE;
              mot_q   <= 1'b0;
              code_q  <= plain;
            end else if (seg_end) begin
              code_q <= plain;
            end else if (short_rpl && code_q == CODE_WR) begin
              code_q <= CODE_WSU;
            end
          end else begin
            if (i2c_defer && code_q == CODE_WR) code_q <= CODE_WSU;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: if (wait_done) state_q <= S_ISSUE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_q  <= '0;
      defer_q <= '0;
    end else begin
      if (rsp_now && i2c_nack)  nack_q  <= nack_q + 1'b1;
      if (rsp_now && i2c_defer) defer_q <= defer_q + 1'b1;
    end
  end

  assign msg_ready_o    = (state_q == S_IDLE);
  assign req_valid_o    = (state_q == S_ISSUE);
  assign req_cmd_o      = {1'b0, mot_q, code_q};
  assign req_addr_o     = addr_q;
  assign req_size_o     = (phase_q == PH_DATA) ? seg_left : '0;
  assign req_ptr_o      = ptr;
  assign done_o         = done_q;
  assign status_o       = sts_q;
  assign nack_events_o  = nack_q;
  assign defer_events_o = defer_q;

  // R1
  start_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_ready_o |=> req_valid_o && req_cmd_o[MOT_BIT] && req_size_o == '0);
  // R3
  close_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_o && rsp_valid_i && !req_cmd_o[MOT_BIT] && req_size_o == '0));
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !rsp_valid_i |=> req_valid_o && $stable(req_cmd_o) && $stable(req_size_o)
                                     && $stable(req_ptr_o));
  // R8
  read_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && rd_q |-> req_cmd_o[1:0] == CODE_RD);
  // R2
  size_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_size_o <= SZ_W'(MAX_CHUNK));

endmodule

// File: tb/aux_i2c_seq_test.sv
module aux_i2c_seq_test;
  localparam int LEN_W = 8, MAX_CHUNK = 16, I2C_KHZ = 10, DEFER_WAIT = 8, CNT_W = 16;
  localparam int SZ_W = $clog2(MAX_CHUNK + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic msg_valid = 0, msg_read = 0;
  logic [6:0] msg_addr = 7'h50;
  logic [LEN_W-1:0] msg_len = '0;
  logic msg_ready, req_valid, rsp_valid = 0, rsp_busy = 0, done;
  logic [3:0] req_cmd, rsp_reply = '0;
  logic [6:0] req_addr;
  logic [SZ_W-1:0] req_size, rsp_count = '0;
  logic [LEN_W-1:0] req_ptr;
  logic [1:0] status;
  logic [CNT_W-1:0] nack_ev, defer_ev;

  aux_i2c_seq #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK), .I2C_KHZ(I2C_KHZ),
                .DEFER_WAIT(DEFER_WAIT), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_read_i(msg_read),
    .msg_addr_i(msg_addr), .msg_len_i(msg_len), .msg_ready_o(msg_ready),
    .req_valid_o(req_valid), .req_cmd_o(req_cmd), .req_addr_o(req_addr),
    .req_size_o(req_size), .req_ptr_o(req_ptr), .rsp_valid_i(rsp_valid),
    .rsp_busy_i(rsp_busy), .rsp_reply_i(rsp_reply), .rsp_count_i(rsp_count),
    .done_o(done), .status_o(status), .nack_events_o(nack_ev), .defer_events_o(defer_ev));

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // responder script: reply {i2c,native}, count (-1 = full), busy flag
  int scr_rpl[64], scr_cnt[64], scr_busy[64];
  int scr_n = 0, scr_i = 0;
  int log_cmd[256], log_size[256], log_ptr[256], log_t[256];
  int n_req = 0;

  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_busy = 0;
      if (req_valid) begin
        if (n_req < 256) begin
          log_cmd[n_req] = req_cmd; log_size[n_req] = req_size;
          log_ptr[n_req] = req_ptr; log_t[n_req] = cyc;
        end
        if (scr_i < scr_n) begin
          rsp_reply = scr_rpl[scr_i][3:0];
          rsp_count = (scr_cnt[scr_i] < 0) ? req_size : scr_cnt[scr_i][SZ_W-1:0];
          rsp_busy  = scr_busy[scr_i][0];
          scr_i++;
        end else begin
          rsp_reply = 4'h0; rsp_count = req_size;
        end
        n_req++;
        rsp_valid = 1;
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=hung exp=finished");
    report();
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic scr_clear();
    scr_n = 0; scr_i = 0;
  endtask

  task automatic scr_add(input int rpl, input int cnt, input int busy, input int times);
    for (int k = 0; k < times; k++) begin
      scr_rpl[scr_n] = rpl; scr_cnt[scr_n] = cnt; scr_busy[scr_n] = busy; scr_n++;
    end
  endtask

  task automatic run_msg(input bit rd, input int len, output int sts);
    n_req = 0;
    @(negedge clk);
    msg_valid = 1; msg_read = rd; msg_len = len[LEN_W-1:0];
    @(negedge clk);
    msg_valid = 0;
    while (!done) @(negedge clk);
    sts = status;
  endtask

  function automatic int exp_base(input int s);
    int t_i2c, t_aux, q;
    t_i2c = ((11 + 9 * s) * 1000 + I2C_KHZ - 1) / I2C_KHZ;
    t_aux = 108 + 8 * s + 500;
    q = (t_i2c + t_aux - 1) / t_aux;
    return (q < 7) ? 7 : q;
  endfunction

  localparam int TV_N = 5;
  localparam int tv_len [TV_N] = '{0, 5, 16, 33, 40};
  localparam int tv_rd  [TV_N] = '{1, 0, 1, 0, 1};

  initial begin
    int sts, exp_def, exp_nack, b16;
    exp_def = 0; exp_nack = 0;
    #1;
    // R12 during and after reset
    chk("R12 ready", msg_ready, 1);
    chk("R12 req_valid", req_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 done", done, 0);
    chk("R12 nack_ev", nack_ev, 0);
    chk("R12 defer_ev", defer_ev, 0);
    chk("R12 ready after", msg_ready, 1);

    // table: all-full replies
    for (int v = 0; v < TV_N; v++) begin
      int len, rd, nd, off;
      len = tv_len[v]; rd = tv_rd[v];
      nd = (len + MAX_CHUNK - 1) / MAX_CHUNK;
      scr_clear();
      run_msg(rd[0], len, sts);
      chk("R4 status ok", sts, 0);
      chk("R2 request count", n_req, 2 + nd);
      chk("R1 start cmd", log_cmd[0], 4 + rd);
      chk("R1 start size", log_size[0], 0);
      chk("R3 close cmd", log_cmd[n_req-1], rd);
      chk("R3 close size", log_size[n_req-1], 0);
      off = 0;
      for (int k = 0; k < nd; k++) begin
        int s;
        s = (len - off < MAX_CHUNK) ? len - off : MAX_CHUNK;
        chk("R2 chunk size", log_size[1+k], s);
        chk("R2 chunk ptr", log_ptr[1+k], off);
        chk("R2 chunk cmd", log_cmd[1+k], 4 + rd);
        off += s;
      end
    end

    // R9 partial read: 40 bytes, first chunk returns 5
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(0, 5, 0, 1);
    run_msg(1, 40, sts);
    chk("R9 status", sts, 0);
    chk("R9 remainder size", log_size[2], 11);
    chk("R9 remainder ptr", log_ptr[2], 5);
    chk("R9 shrunk size", log_size[3], 5);
    chk("R9 shrunk ptr", log_ptr[3], 16);
    chk("R9 last size", log_size[7], 4);
    chk("R9 request count", n_req, 9);

    // R8 short write becomes status update
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(0, 4, 0, 1);
    run_msg(0, 10, sts);
    chk("R8 wsu cmd", log_cmd[2], 6);
    chk("R8 wsu size", log_size[2], 6);
    chk("R8 wsu ptr", log_ptr[2], 4);
    chk("R3 close after wsu", log_cmd[3], 0);

    // R8/R5 I2C defer on write start packet
    scr_clear(); scr_add(8, -1, 0, 1);
    run_msg(0, 20, sts); exp_def++;
    chk("R8 defer to wsu", log_cmd[1], 6);
    chk("R8 restored on chunk", log_cmd[2], 4);
    chk("R5 defer gap", log_t[1] - log_t[0], DEFER_WAIT + 2);
    chk("R5 plain gap", log_t[2] - log_t[1], 2);
    chk("R11 defer count", defer_ev, exp_def);

    // R5 busy retries
    scr_clear(); scr_add(0, -1, 1, 3);
    run_msg(1, 4, sts);
    chk("R5 busy status", sts, 0);
    chk("R5 busy requests", n_req, 6);
    chk("R5 busy gap", log_t[1] - log_t[0], 2);

    // R4 native NACK
    scr_clear(); scr_add(1, -1, 0, 1);
    run_msg(1, 8, sts);
    chk("R4 native nack status", sts, 1);
    chk("R3 close after error", log_cmd[1], 1);
    chk("R3 requests after error", n_req, 2);

    // R4/R11 I2C NACK on data
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(4, -1, 0, 1);
    run_msg(1, 8, sts); exp_nack++;
    chk("R4 i2c nack status", sts, 1);
    chk("R11 nack count", nack_ev, exp_nack);
    chk("R4 i2c nack requests", n_req, 3);

    // R4 invalid native and invalid I2C
    scr_clear(); scr_add(3, -1, 0, 1);
    run_msg(1, 2, sts);
    chk("R4 invalid native", sts, 1);
    scr_clear(); scr_add(12, -1, 0, 1);
    run_msg(1, 2, sts);
    chk("R4 invalid i2c", sts, 1);

    // R10 zero-count data reply
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(0, 0, 0, 1);
    run_msg(1, 8, sts);
    chk("R10 proto status", sts, 2);
    chk("R10 close sent", n_req, 3);

    // R6 native defer exhaustion on address-only packet
    scr_clear(); scr_add(2, -1, 0, exp_base(0));
    run_msg(1, 0, sts);
    chk("R6 floor exhaust status", sts, 1);
    chk("R6 floor attempts", n_req, exp_base(0) + 1);

    // R6 size-dependent limit on 16-byte packet
    b16 = exp_base(16);
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(2, -1, 0, b16);
    run_msg(1, 16, sts);
    chk("R6 size16 exhaust status", sts, 1);
    chk("R6 size16 attempts", n_req, b16 + 2);
    scr_clear(); scr_add(0, -1, 0, 1); scr_add(2, -1, 0, b16 - 1);
    run_msg(1, 16, sts);
    chk("R6 size16 last-try ok", sts, 0);
    chk("R6 size16 last-try requests", n_req, b16 + 2);

    // R7 I2C defers extend the limit by at most 7
    scr_clear(); scr_add(8, -1, 0, 14);
    run_msg(1, 3, sts); exp_def += 14;
    chk("R7 extended exhaust status", sts, 1);
    chk("R7 extended attempts", n_req, 15);
    chk("R11 defer count many", defer_ev, exp_def);
    scr_clear(); scr_add(8, -1, 0, 13);
    run_msg(1, 0, sts); exp_def += 13;
    chk("R7 extended last-try ok", sts, 0);
    chk("R7 extended last-try requests", n_req, 15);

    report();
  end

endmodule